// File: doc/BRIEF.md
# Byte Load Lane Placement Unit

This unit carries out one instruction of a packed-data extension. The instruction fetches a single byte from memory and lays it into a 32-bit auxiliary register. A caller hands the unit a 32-bit instruction word. The unit checks that the word belongs to it and pulls out its fields. It reads a base value from the general register file and adds a signed 8-bit displacement to form a byte address. It then issues one read on a request/response memory port.

When the byte returns, the unit shapes a 32-bit result using one of eight placement modes. The first four modes drop the byte into a single lane and keep the other three lanes of the target register. The other four modes ignore the old contents and build a fresh pattern: zero-padded halves, shifted zero-padded halves, sign-extended halves, or the byte copied into all four lanes. The result leaves through a one-cycle write strobe to the auxiliary register file. The testbench models both register files and memory as combinational read ports.

Stream rules:
- An instruction is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole time the unit is working.
- Once `mem_req_valid` rises, it stays high with a constant address until the cycle `mem_req_ready` is high.
- The response has no ready signal. The unit takes `mem_rsp_valid` only while it is waiting for data, and drops it at any other time.

Top module: `byte_lane_load_unit`

## Requirements
- R1: A word is accepted as this instruction only when bits 31:26 equal 6'h1C and bits 5:0 equal 6'h22. Any other word presented with `in_valid` is dropped: no memory request, no register write, and `in_ready` stays high.
- R2: Bits 25:21 select the base general register, which appears on `gpr_idx`. The request address is that register's value plus bits 17:10 sign-extended to 32 bits. Index 0 reads as zero from the port.
- R3: Each accepted instruction issues exactly one memory request. While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold steady, and the request drops in the cycle after the handshake.
- R4: One cycle after the cycle in which `mem_rsp_valid` is seen, `aux_we` is high for exactly one cycle, and `aux_wr_idx` carries bits 9:6 of the word.
- R5: Modes 0, 1, 2 and 3 (bits 20:18) replace only bits 7:0, 15:8, 23:16 or 31:24 respectively of the target register's current value with the byte, and keep every other bit.
- R6: Mode 4 writes {8'h00, b, 8'h00, b}, and mode 5 writes {b, 8'h00, b, 8'h00}, where b is the byte.
- R7: Mode 6 writes {{8{b[7]}}, b, {8{b[7]}}, b}.
- R8: Mode 7 writes {b, b, b, b}.
- R9: For modes 4 to 7, the written value does not depend on the target register's prior contents.
- R10: From acceptance until the cycle after the write strobe, `busy` is high and `in_ready` is low. A word offered in that window is not taken.
- R11: Synchronous active-high `rst` returns the unit to idle with no request and no write strobe. A response that arrives after reset causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take an instruction |
| in_instr | input | 32 | Instruction word |
| busy | output | 1 | An instruction is in progress |
| gpr_idx | output | 5 | General register read index |
| gpr_data | input | 32 | General register read data |
| aux_rd_idx | output | 4 | Auxiliary register read index |
| aux_rd_data | input | 32 | Auxiliary register read data |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Returned byte |
| aux_we | output | 1 | Auxiliary register write strobe |
| aux_wr_idx | output | 4 | Auxiliary register write index |
| aux_wr_data | output | 32 | Value written |

## Verification
The assertions check on every cycle that a stalled request keeps its valid and address and that a request ends after its handshake. They also check that the write strobe never lasts two cycles, that acceptance leads straight into the busy state, and that the pattern modes produce lane relations fitting their shape (equal lanes, zero lanes, sign lanes). The bench scenarios are the only way to show the exact lane a single-lane mode touches and that the other lanes keep their old bits. They also show the computed address for positive, negative and zero-index bases, that foreign words are dropped, that pattern results ignore old contents, and that reset in the middle of an instruction discards it.

// File: rtl/blm_pkg.sv
package blm_pkg;
  localparam int XLEN      = 32;
  localparam int BYTE_W    = 8;
  localparam int LANES     = XLEN / BYTE_W;
  localparam int GPR_IDX_W = 5;
  localparam int AUX_IDX_W = 4;
  localparam int DISP_W    = 8;
  localparam int OP_W      = 6;

  localparam logic [OP_W-1:0] MAJOR_OP = 6'h1C;
  localparam logic [OP_W-1:0] FUNC_OP  = 6'h22;

  typedef enum logic [2:0] {
    PLACE_L0     = 3'd0,
    PLACE_L1     = 3'd1,
    PLACE_L2     = 3'd2,
    PLACE_L3     = 3'd3,
    PLACE_ZPAD   = 3'd4,
    PLACE_ZSHIFT = 3'd5,
    PLACE_SEXT   = 3'd6,
    PLACE_SPLAT  = 3'd7
  } place_e;

  typedef struct packed {
    logic [GPR_IDX_W-1:0] base;
    place_e               mode;
    logic [DISP_W-1:0]    disp;
    logic [AUX_IDX_W-1:0] tgt;
  } fields_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CALC = 3'd1,
    S_REQ  = 3'd2,
    S_WAIT = 3'd3,
    S_WB   = 3'd4
  } state_e;
endpackage

// File: rtl/blm_decode.sv
module blm_decode
  import blm_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output logic            match,
  output fields_t         fields
);
  assign match         = (instr[31:26] == MAJOR_OP) && (instr[5:0] == FUNC_OP);
  assign fields.base   = instr[25:21];
  assign fields.mode   = place_e'(instr[20:18]);
  assign fields.disp   = instr[17:10];
  assign fields.tgt    = instr[9:6];
endmodule

// File: rtl/blm_agen.sv
module blm_agen #(
  parameter int AW = 32,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base_val,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] addr
);
  localparam int EXT_W = AW - DW;
  logic [AW-1:0] disp_ext;
  assign disp_ext = {{EXT_W{disp[DW-1]}}, disp};
  assign addr     = base_val + disp_ext;
endmodule

// File: rtl/blm_compose.sv
module blm_compose
  import blm_pkg::*;
(
  input  place_e              mode,
  input  logic [XLEN-1:0]     old_val,
  input  logic [BYTE_W-1:0]   data_byte,
  output logic [XLEN-1:0]     new_val
);
  localparam int SEL_W = $clog2(LANES);

  logic [BYTE_W-1:0] sign_fill;
  assign sign_fill = {BYTE_W{data_byte[BYTE_W-1]}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit EVEN = (g % 2) == 0;
    logic [BYTE_W-1:0] lane_val;
    always_comb begin
      unique case (mode)
        PLACE_L0, PLACE_L1, PLACE_L2, PLACE_L3:
          lane_val = (mode[SEL_W-1:0] == SEL_W'(g)) ? data_byte
                                                    : old_val[g*BYTE_W +: BYTE_W];
        PLACE_ZPAD:   lane_val = EVEN ? data_byte : '0;
        PLACE_ZSHIFT: lane_val = EVEN ? '0 : data_byte;
        PLACE_SEXT:   lane_val = EVEN ? data_byte : sign_fill;
        default:      lane_val = data_byte;
      endcase
    end
    assign new_val[g*BYTE_W +: BYTE_W] = lane_val;
  end
endmodule

// File: rtl/byte_lane_load_unit.sv
module byte_lane_load_unit
  import blm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_instr,
  output logic        busy,
  output logic [4:0]  gpr_idx,
  input  logic [31:0] gpr_data,
  output logic [3:0]  aux_rd_idx,
  input  logic [31:0] aux_rd_data,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [7:0]  mem_rsp_data,
  output logic        aux_we,
  output logic [3:0]  aux_wr_idx,
  output logic [31:0] aux_wr_data
);
  state_e          state_q;
  fields_t         fields_d;
  fields_t         fields_q;
  logic            is_ours;
  logic [XLEN-1:0] addr_d;
  logic [XLEN-1:0] addr_q;
  logic [XLEN-1:0] result_d;
  logic [XLEN-1:0] result_q;
  logic            accept;

  blm_decode u_decode (
    .instr  (in_instr),
    .match  (is_ours),
    .fields (fields_d)
  );

  blm_agen #(.AW(XLEN), .DW(DISP_W)) u_agen (
    .base_val (gpr_data),
    .disp     (fields_q.disp),
    .addr     (addr_d)
  );

  blm_compose u_compose (
    .mode      (fields_q.mode),
    .old_val   (aux_rd_data),
    .data_byte (mem_rsp_data),
    .new_val   (result_d)
  );

  assign in_ready = (state_q == S_IDLE);
  assign busy     = (state_q != S_IDLE);
  assign accept   = in_valid && in_ready && is_ours;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      fields_q <= '0;
      addr_q   <= '0;
      result_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          fields_q <= fields_d;
          state_q  <= S_CALC;
        end
        S_CALC: begin
          addr_q  <= addr_d;
          state_q <= S_REQ;
        end
        S_REQ:  if (mem_req_ready) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          result_q <= result_d;
          state_q  <= S_WB;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign gpr_idx       = fields_q.base;
  assign aux_rd_idx    = fields_q.tgt;
  assign mem_req_valid = (state_q == S_REQ);
  assign mem_req_addr  = addr_q;
  assign aux_we        = (state_q == S_WB);
  assign aux_wr_idx    = fields_q.tgt;
  assign aux_wr_data   = result_q;

  // R3: stalled request keeps valid and address
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R3: one request per instruction
  a_r3_single_req: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
  // R4: write strobe lasts one cycle
  a_r4_we_pulse: assert property (@(posedge clk) disable iff (rst)
    aux_we |=> !aux_we);
  // R10: acceptance moves the unit into busy
  a_r10_accept_busy: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_instr[31:26] == MAJOR_OP) && (in_instr[5:0] == FUNC_OP)
      |=> busy && !in_ready);
  // R1: a foreign word leaves the unit idle
  a_r1_foreign_idle: assert property (@(posedge clk) disable iff (rst)
    in_ready && (in_instr[5:0] != FUNC_OP) |=> in_ready);
  // R8: splat mode writes four equal lanes
  a_r8_splat: assert property (@(posedge clk) disable iff (rst)
    aux_we && fields_q.mode == PLACE_SPLAT |->
      aux_wr_data[31:24] == aux_wr_data[7:0] && aux_wr_data[23:16] == aux_wr_data[7:0]
      && aux_wr_data[15:8] == aux_wr_data[7:0]);
  // R7: sign-extended halves
  a_r7_sext: assert property (@(posedge clk) disable iff (rst)
    aux_we && fields_q.mode == PLACE_SEXT |->
      aux_wr_data[31:24] == {8{aux_wr_data[7]}} && aux_wr_data[15:8] == {8{aux_wr_data[7]}}
      && aux_wr_data[23:16] == aux_wr_data[7:0]);
  // R6: zero-padded halves
  a_r6_zpad: assert property (@(posedge clk) disable iff (rst)
    aux_we && fields_q.mode == PLACE_ZPAD |->
      aux_wr_data[31:24] == 8'h00 && aux_wr_data[15:8] == 8'h00
      && aux_wr_data[23:16] == aux_wr_data[7:0]);
endmodule

// File: tb/test_byte_lane_load_unit.sv
module test_byte_lane_load_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        busy;
  logic [4:0]  gpr_idx;
  logic [31:0] gpr_data;
  logic [3:0]  aux_rd_idx;
  logic [31:0] aux_rd_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        aux_we;
  logic [3:0]  aux_wr_idx;
  logic [31:0] aux_wr_data;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int we_cnt = 0;
  logic [31:0] gpr_mem [32];
  logic [31:0] aux_mem [16];

  always #2.5 clk = ~clk;

  byte_lane_load_unit i_byte_lane_load_unit (
    .clk, .rst, .in_valid, .in_ready, .in_instr, .busy,
    .gpr_idx, .gpr_data, .aux_rd_idx, .aux_rd_data,
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_data,
    .aux_we, .aux_wr_idx, .aux_wr_data
  );

  assign gpr_data    = (gpr_idx == 5'd0) ? 32'h0 : gpr_mem[gpr_idx];
  assign aux_rd_data = aux_mem[aux_rd_idx];

  always @(posedge clk) begin
    if (aux_we) aux_mem[aux_wr_idx] <= aux_wr_data;
    if (!rst && mem_req_valid && mem_req_ready) req_cnt <= req_cnt + 1;
    if (!rst && aux_we) we_cnt <= we_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] base, input logic [2:0] mode,
                                      input logic [7:0] disp, input logic [3:0] tgt);
    return {6'h1C, base, mode, disp, tgt, 6'h22};
  endfunction

  function automatic logic [31:0] f_exp(input logic [2:0] m, input logic [31:0] o,
                                        input logic [7:0] b);
    case (m)
      3'd0: return {o[31:8], b};
      3'd1: return {o[31:16], b, o[7:0]};
      3'd2: return {o[31:24], b, o[15:0]};
      3'd3: return {b, o[23:0]};
      3'd4: return {8'h00, b, 8'h00, b};
      3'd5: return {b, 8'h00, b, 8'h00};
      3'd6: return {{8{b[7]}}, b, {8{b[7]}}, b};
      default: return {b, b, b, b};
    endcase
  endfunction

  task automatic do_instr(input logic [31:0] w, input int bp, input int dly,
                          input logic [7:0] b, input bit poke, input string tag);
    logic [4:0]  base = w[25:21];
    logic [7:0]  d = w[17:10];
    logic [3:0]  tgt = w[9:6];
    logic [31:0] bv = (base == 5'd0) ? 32'h0 : gpr_mem[base];
    logic [31:0] exp_addr = bv + {{24{d[7]}}, d};
    logic [31:0] exp_val = f_exp(w[20:18], aux_mem[tgt], b);
    int r0 = req_cnt;
    int k = 0;
    @(negedge clk); in_valid = 1'b1; in_instr = w;
    @(negedge clk); in_valid = 1'b0;
    if (poke) begin in_valid = 1'b1; in_instr = w ^ 32'h0000_0400; end
    while (!mem_req_valid && k < 50) begin
      if (poke) check(!in_ready && busy, "R10 ready while busy", {31'b0, in_ready}, 32'h0);
      @(negedge clk); k++;
    end
    check(mem_req_valid, "R3 request issued", {31'b0, mem_req_valid}, 32'h1);
    check(mem_req_addr == exp_addr, "R2 address", mem_req_addr, exp_addr);
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == exp_addr, "R3 hold under stall",
            mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk); mem_req_ready = 1'b0;
    check(!mem_req_valid, "R3 request drops", {31'b0, mem_req_valid}, 32'h0);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check(!aux_we, "R4 no early write", {31'b0, aux_we}, 32'h0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = b;
    @(negedge clk); mem_rsp_valid = 1'b0;
    if (poke) check(!in_ready, "R10 ready in writeback", {31'b0, in_ready}, 32'h0);
    in_valid = 1'b0;
    check(aux_we, "R4 write strobe", {31'b0, aux_we}, 32'h1);
    check(aux_wr_idx == tgt, "R4 write index", {28'b0, aux_wr_idx}, {28'b0, tgt});
    check(aux_wr_data == exp_val, tag, aux_wr_data, exp_val);
    @(negedge clk);
    check(!aux_we, "R4 strobe one cycle", {31'b0, aux_we}, 32'h0);
    check(in_ready && !busy, "R10 idle after write", {31'b0, in_ready}, 32'h1);
    check(req_cnt - r0 == 1, "R3 one request", req_cnt - r0, 32'd1);
  endtask

  task automatic t_reset;
    check(in_ready && !busy, "R11 reset idle", {31'b0, in_ready}, 32'h1);
    check(!mem_req_valid && !aux_we, "R11 reset outputs",
          {30'b0, mem_req_valid, aux_we}, 32'h0);
  endtask

  task automatic t_lane_modes;
    gpr_mem[3] = 32'h0000_1000;
    aux_mem[5] = 32'hA1B2_C3D4;
    do_instr(enc(5'd3, 3'd0, 8'h10, 4'd5), 0, 0, 8'h5E, 1'b0, "R5 lane0");
    do_instr(enc(5'd3, 3'd1, 8'hF0, 4'd5), 1, 2, 8'h6F, 1'b0, "R5 lane1");
    do_instr(enc(5'd0, 3'd2, 8'h7F, 4'd5), 0, 1, 8'h80, 1'b0, "R5 lane2 R2 base0");
    do_instr(enc(5'd3, 3'd3, 8'h80, 4'd5), 2, 0, 8'h01, 1'b0, "R5 lane3");
  endtask

  task automatic t_pattern_modes;
    gpr_mem[17] = 32'hFFFF_FFF0;
    for (int s = 0; s < 2; s++) begin
      aux_mem[9] = (s == 0) ? 32'h0 : 32'hDEAD_BEEF;
      do_instr(enc(5'd17, 3'd4, 8'h20, 4'd9), 0, 0, 8'hC7, 1'b0, "R6 R9 zero pad");
      aux_mem[9] = (s == 0) ? 32'hFFFF_FFFF : 32'h1234_5678;
      do_instr(enc(5'd17, 3'd5, 8'h01, 4'd9), 1, 0, 8'h3C, 1'b0, "R6 R9 shifted pad");
      aux_mem[9] = (s == 0) ? 32'h5555_5555 : 32'h0;
      do_instr(enc(5'd17, 3'd6, 8'hFE, 4'd9), 0, 1, (s == 0) ? 8'h91 : 8'h42, 1'b0,
               "R7 R9 sign halves");
      aux_mem[9] = (s == 0) ? 32'hAAAA_AAAA : 32'h0F0F_0F0F;
      do_instr(enc(5'd17, 3'd7, 8'h00, 4'd9), 0, 0, 8'hE4, 1'b0, "R8 R9 splat");
    end
  endtask

  task automatic t_foreign;
    int r0 = req_cnt;
    int w0 = we_cnt;
    @(negedge clk); in_valid = 1'b1; in_instr = {6'h1C, 20'h12345, 6'h23};
    @(negedge clk);
    check(in_ready, "R1 ready on foreign func", {31'b0, in_ready}, 32'h1);
    in_instr = {6'h00, 20'h12345, 6'h22};
    @(negedge clk);
    check(in_ready, "R1 ready on foreign major", {31'b0, in_ready}, 32'h1);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(req_cnt == r0 && !mem_req_valid, "R1 no request", req_cnt - r0, 32'd0);
    check(we_cnt == w0, "R1 no write", we_cnt - w0, 32'd0);
  endtask

  task automatic t_busy;
    gpr_mem[8] = 32'h0000_4000;
    aux_mem[2] = 32'h1111_2222;
    do_instr(enc(5'd8, 3'd1, 8'h04, 4'd2), 3, 2, 8'h99, 1'b1, "R10 R5 lane1 busy");
  endtask

  task automatic t_mid_reset;
    int w0 = we_cnt;
    int k = 0;
    gpr_mem[4] = 32'h0000_0200;
    @(negedge clk); in_valid = 1'b1; in_instr = enc(5'd4, 3'd7, 8'h00, 4'd1);
    @(negedge clk); in_valid = 1'b0;
    while (!mem_req_valid && k < 50) begin @(negedge clk); k++; end
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!mem_req_valid && !busy && in_ready, "R11 reset mid instruction",
          {30'b0, mem_req_valid, busy}, 32'h0);
    mem_rsp_valid = 1'b1; mem_rsp_data = 8'h77;
    @(negedge clk); mem_rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(we_cnt == w0 && !aux_we, "R11 late response ignored", we_cnt - w0, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) gpr_mem[i] = 32'h100 * i;
    for (int i = 0; i < 16; i++) aux_mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lane_modes();
    t_pattern_modes();
    t_foreign();
    t_busy();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule